// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM device out of power-up. It stays idle, with clock enable low and a NOP on the command pins, until software does a load-config write that sets the init bit, which is bit 7 of configuration word 0. Then it waits until enough clock cycles have passed since reset to cover the 200 µs power-and-clock settling time. After that it raises clock enable and plays out the fixed power-up command program. Each step is spaced by the precharge, mode-load and refresh timing counts.

The two mode-register words are built from the configuration fields: burst length, burst type, CAS latency (half-cycle settings included), output drive strength and the QFC enable. When the program finishes, a sticky done flag rises. The command scheduler uses this flag to hold back all reads and writes until initialization is complete. Normal traffic and the data path are outside this block.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted and after it is released, clock enable is low, the command pins show NOP ({cs,ras,cas,we} = 0111), the bank and address buses are zero, and the done flag is low.
- R2: The sequence starts only on a clock edge where `cfgLoad` is high and `cfgInitBit` (bit 7 of configuration word 0) is 1. A load with the bit at 0 has no effect.
- R3: Clock enable stays low until STABLE_CYCLES = CLK_MHZ*WAIT_US edges have passed since reset. If the trigger is taken at edge T (edges counted from the first edge after reset), clock enable rises after edge max(T, STABLE_CYCLES)+1 with a NOP on the pins, and then stays high.
- R4: The commands follow in this order: PRECHARGE ALL (0010, address bit 10 set), load extended mode, load mode with DLL reset, PRECHARGE ALL, AUTO REFRESH (0001), AUTO REFRESH, load mode without DLL reset. A mode load is 0000. The pins show NOP in every other cycle. Bank and address are zero except during precharge and mode loads.
- R5: The first precharge follows one cycle after clock enable rises. Each later command comes exactly tRp cycles after a precharge, tMrd cycles after a mode load, and tRfc cycles after a refresh. A programmed count of 0 acts as 1.
- R6: A base mode load uses bank 00. Its address fields are:
  - A[2:0] is 001, 010 or 011 for burst-length select 0, 1 or 2 (lengths 2, 4, 8).
  - A3 is the burst type (1 = interleaved).
  - A[6:4] is the CAS latency code: 101 for select 0 (1.5), 010 for select 1 (2.0), 110 for select 2 (2.5), 011 for select 3 (3.0).
  - A8 is 1 only on the first mode load. All other bits are 0.
- R7: The extended mode load uses bank 01. A0 is 0 (DLL enabled), A1 selects reduced drive strength, A2 enables QFC, and all other bits are 0.
- R8: The done flag rises tMrd cycles after the final mode load and stays high until reset. Later loads, including ones that clear the init bit, issue no command and do not lower it.
- R9: A trigger taken while the sequence is waiting or running does not restart or shift it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Load-config write strobe for configuration word 0 |
| cfgInitBit | input | 1 | Bit 7 of the written configuration word (init request) |
| burstLenSel | input | 2 | 0: length 2, 1: length 4, 2: length 8 |
| burstInterleave | input | 1 | 1 selects interleaved burst order |
| casSel | input | 2 | 0: 1.5, 1: 2.0, 2: 2.5, 3: 3.0 cycles |
| driveReduced | input | 1 | Reduced output drive strength |
| qfcEnable | input | 1 | Enables the QFC function |
| tRp | input | GAP_W | Precharge gap in cycles |
| tMrd | input | GAP_W | Mode-load gap in cycles |
| tRfc | input | GAP_W | Refresh gap in cycles |
| ckeOut | output | 1 | Memory clock enable |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| bankAddr | output | BA_W | Bank address |
| memAddr | output | ROW_W | Address bus |
| initDone | output | 1 | Initialization complete; reads and writes allowed |

## Verification
Every result is tied to one edge index counted from reset release:
- Clock enable rises after edge max(T, STABLE_CYCLES)+1.
- Each later command lands exactly one programmed gap (tRp, tMrd or tRfc) after the one before it.
- Done lands tMrd after the last mode load.

The bench computes these edge numbers from the trigger edge and the programmed counts alone. Between clock edges it compares clock enable, the command pins, bank, address and done against the values expected for the edge just passed, so a command one cycle early or late shows up in the cycle where it lands. Zero gaps, the latest and the smallest settle start, and triggers during a run or after done are each covered in their own scenario.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    STEP_CKE,
    STEP_PRE1,
    STEP_EMR,
    STEP_MR_DLLRST,
    STEP_PRE2,
    STEP_REF1,
    STEP_REF2,
    STEP_MR_FINAL
  } step_e;

  typedef struct packed {
    logic  issue;
    step_e step;
  } seq_strobe_t;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_LMR = 4'b0000;

  function automatic logic [2:0] casCode(input logic [1:0] sel);
    case (sel)
      2'd0:    casCode = 3'b101;
      2'd1:    casCode = 3'b010;
      2'd2:    casCode = 3'b110;
      default: casCode = 3'b011;
    endcase
  endfunction

  function automatic logic [2:0] burstCode(input logic [1:0] sel);
    case (sel)
      2'd0:    burstCode = 3'b001;
      2'd1:    burstCode = 3'b010;
      default: burstCode = 3'b011;
    endcase
  endfunction

endpackage

// File: rtl/ddr_init_ctrl.sv
module ddr_init_ctrl
  import ddr_init_pkg::*;
#(
  parameter int GAP_W         = 4,
  parameter int STABLE_CYCLES = 50000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic             cfgInitBit,
  input  logic [GAP_W-1:0] tRp,
  input  logic [GAP_W-1:0] tMrd,
  input  logic [GAP_W-1:0] tRfc,
  output seq_strobe_t      strobe,
  output logic             initDone
);

  localparam int UP_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [UP_W-1:0]  STABLE_V = UP_W'(STABLE_CYCLES);
  localparam logic [GAP_W-1:0] ONE      = GAP_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN, S_DONE} state_e;

  state_e           state;
  step_e            curStep;
  step_e            nextStep;
  logic [GAP_W-1:0] gapCnt;
  logic [UP_W-1:0]  upCnt;
  logic             stableOk;
  logic             gapExpired;

  function automatic logic [GAP_W-1:0] gapFor(input step_e s, input logic [GAP_W-1:0] rp,
                                                input logic [GAP_W-1:0] mrd,
                                                input logic [GAP_W-1:0] rfc);
    logic [GAP_W-1:0] g;
    case (s)
      STEP_PRE1, STEP_PRE2: g = rp;
      STEP_REF1, STEP_REF2: g = rfc;
      STEP_CKE:             g = ONE;
      default:              g = mrd;
    endcase
    gapFor = (g == '0) ? ONE : g;
  endfunction

  // settle counter runs from reset release, saturating at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                upCnt <= '0;
    else if (upCnt != STABLE_V) upCnt <= upCnt + 1'b1;
  end

  assign stableOk   = (upCnt == STABLE_V);
  assign gapExpired = (gapCnt == ONE);
  assign nextStep   = step_e'(curStep + 3'd1);
  assign initDone   = (state == S_DONE);

  always_comb begin
    strobe.issue = 1'b0;
    strobe.step  = STEP_CKE;
    case (state)
      S_WAIT: strobe.issue = stableOk;
      S_RUN: begin
        strobe.step  = nextStep;
        strobe.issue = gapExpired && (curStep != STEP_MR_FINAL);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      curStep <= STEP_CKE;
      gapCnt  <= ONE;
    end else begin
      case (state)
        S_IDLE: if (cfgLoad && cfgInitBit) state <= S_WAIT;
        S_WAIT: if (stableOk) begin
          state   <= S_RUN;
          curStep <= STEP_CKE;
          gapCnt  <= ONE;
        end
        S_RUN: begin
          if (gapExpired) begin
            if (curStep == STEP_MR_FINAL) begin
              state <= S_DONE;
            end else begin
              curStep <= nextStep;
              gapCnt  <= gapFor(nextStep, tRp, tMrd, tRfc);
            end
          end else begin
            gapCnt <= gapCnt - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ddr_init_dp.sv
module ddr_init_dp
  import ddr_init_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_strobe_t      strobe,
  input  logic [1:0]       burstLenSel,
  input  logic             burstInterleave,
  input  logic [1:0]       casSel,
  input  logic             driveReduced,
  input  logic             qfcEnable,
  output logic             cke,
  output logic [3:0]       cmd,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr
);

  localparam int PRE_ALL_BIT = 10;
  localparam int DLL_RST_BIT = 8;

  logic [3:0]       nextCmd;
  logic [BA_W-1:0]  nextBa;
  logic [ROW_W-1:0] nextAddr;

  always_comb begin
    nextCmd  = CMD_NOP;
    nextBa   = '0;
    nextAddr = '0;
    if (strobe.issue) begin
      case (strobe.step)
        STEP_PRE1, STEP_PRE2: begin
          nextCmd               = CMD_PRE;
          nextAddr[PRE_ALL_BIT] = 1'b1;
        end
        STEP_REF1, STEP_REF2: nextCmd = CMD_REF;
        STEP_EMR: begin
          nextCmd     = CMD_LMR;
          nextBa      = BA_W'(1);
          nextAddr[1] = driveReduced;
          nextAddr[2] = qfcEnable;
        end
        STEP_MR_DLLRST, STEP_MR_FINAL: begin
          nextCmd               = CMD_LMR;
          nextAddr[2:0]         = burstCode(burstLenSel);
          nextAddr[3]           = burstInterleave;
          nextAddr[6:4]         = casCode(casSel);
          nextAddr[DLL_RST_BIT] = (strobe.step == STEP_MR_DLLRST);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cke  <= 1'b0;
      cmd  <= CMD_NOP;
      ba   <= '0;
      addr <= '0;
    end else begin
      cmd  <= nextCmd;
      ba   <= nextBa;
      addr <= nextAddr;
      if (strobe.issue && strobe.step == STEP_CKE) cke <= 1'b1;
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int CLK_MHZ = 250,
  parameter int WAIT_US = 200,
  parameter int GAP_W   = 4,
  parameter int ROW_W   = 12,
  parameter int BA_W    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic             cfgInitBit,
  input  logic [1:0]       burstLenSel,
  input  logic             burstInterleave,
  input  logic [1:0]       casSel,
  input  logic             driveReduced,
  input  logic             qfcEnable,
  input  logic [GAP_W-1:0] tRp,
  input  logic [GAP_W-1:0] tMrd,
  input  logic [GAP_W-1:0] tRfc,
  output logic             ckeOut,
  output logic             csN,
  output logic             rasN,
  output logic             casN,
  output logic             weN,
  output logic [BA_W-1:0]  bankAddr,
  output logic [ROW_W-1:0] memAddr,
  output logic             initDone
);

  localparam int STABLE_CYCLES = CLK_MHZ * WAIT_US;

  seq_strobe_t strobe;
  logic [3:0]  cmdBits;

  ddr_init_ctrl #(.GAP_W(GAP_W), .STABLE_CYCLES(STABLE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgInitBit(cfgInitBit),
    .tRp(tRp), .tMrd(tMrd), .tRfc(tRfc), .strobe(strobe), .initDone(initDone)
  );

  ddr_init_dp #(.ROW_W(ROW_W), .BA_W(BA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .burstLenSel(burstLenSel),
    .burstInterleave(burstInterleave), .casSel(casSel), .driveReduced(driveReduced),
    .qfcEnable(qfcEnable), .cke(ckeOut), .cmd(cmdBits), .ba(bankAddr), .addr(memAddr)
  );

  assign {csN, rasN, casN, weN} = cmdBits;

endmodule

// File: rtl/ddr_init_checker.sv
module ddr_init_checker
  import ddr_init_pkg::*;
#(
  parameter int STABLE_CYCLES = 50000,
  parameter int BA_W          = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            ckeOut,
  input logic            csN,
  input logic            rasN,
  input logic            casN,
  input logic            weN,
  input logic [BA_W-1:0] bankAddr,
  input logic            initDone
);

  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STABLE_CYCLES);

  logic [CW-1:0] sinceRst;
  logic [3:0]    pins;

  assign pins = {csN, rasN, casN, weN};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceRst <= '0;
    else if (sinceRst != LIMIT) sinceRst <= sinceRst + 1'b1;
  end

  a_r3_no_cke_before_stable: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < LIMIT) |-> !ckeOut);

  a_r3_cke_stays_high: assert property (@(posedge clk) disable iff (!rstN)
    ckeOut |=> ckeOut);

  a_r4_nop_while_cke_low: assert property (@(posedge clk) disable iff (!rstN)
    !ckeOut |-> (pins == CMD_NOP));

  a_r7_mode_load_bank: assert property (@(posedge clk) disable iff (!rstN)
    (pins == CMD_LMR) |-> (bankAddr < BA_W'(2)));

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (pins == CMD_NOP && ckeOut));

endmodule

bind ddr_init_seq ddr_init_checker #(.STABLE_CYCLES(STABLE_CYCLES), .BA_W(BA_W)) u_chk (
  .clk(clk), .rstN(rstN), .ckeOut(ckeOut), .csN(csN), .rasN(rasN), .casN(casN),
  .weN(weN), .bankAddr(bankAddr), .initDone(initDone)
);

// File: tb/sim_ddr_init_seq.sv
`timescale 1ns/1ps
module sim_ddr_init_seq;

  localparam int CLK_MHZ = 250;
  localparam int WAIT_US = 1;
  localparam int STABLE  = CLK_MHZ * WAIT_US;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgLoad = 1'b0, cfgInitBit = 1'b0;
  logic [1:0] burstLenSel = 2'd1, casSel = 2'd1;
  logic       burstInterleave = 1'b0, driveReduced = 1'b0, qfcEnable = 1'b0;
  logic [3:0] tRp = 4'd3, tMrd = 4'd2, tRfc = 4'd10;
  logic       ckeOut, csN, rasN, casN, weN, initDone;
  logic [1:0]  bankAddr;
  logic [11:0] memAddr;

  int checks = 0, fails = 0;
  bit finished = 0;

  ddr_init_seq #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US)) u0 (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgInitBit(cfgInitBit),
    .burstLenSel(burstLenSel), .burstInterleave(burstInterleave), .casSel(casSel),
    .driveReduced(driveReduced), .qfcEnable(qfcEnable), .tRp(tRp), .tMrd(tMrd), .tRfc(tRfc),
    .ckeOut(ckeOut), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankAddr(bankAddr), .memAddr(memAddr), .initDone(initDone)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (edge %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------- behavioural reference model ----------
  int cyc = 0;
  int trigCyc = -1;
  int evCyc [8];     // 0: cke rise, 1..7: commands
  int doneCyc = -1;

  function automatic int gap(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int clCode(input int sel);
    case (sel)
      0: return 5; 1: return 2; 2: return 6; default: return 3;
    endcase
  endfunction

  function automatic int modeWord(input bit dll);
    return (burstLenSel + 1) | (int'(burstInterleave) << 3) | (clCode(casSel) << 4)
           | (int'(dll) << 8);
  endfunction

  task automatic buildSchedule();
    int s;
    s = ((trigCyc > STABLE) ? trigCyc : STABLE) + 1;
    evCyc[0] = s;
    evCyc[1] = s + 1;
    evCyc[2] = evCyc[1] + gap(tRp);
    evCyc[3] = evCyc[2] + gap(tMrd);
    evCyc[4] = evCyc[3] + gap(tMrd);
    evCyc[5] = evCyc[4] + gap(tRp);
    evCyc[6] = evCyc[5] + gap(tRfc);
    evCyc[7] = evCyc[6] + gap(tRfc);
    doneCyc  = evCyc[7] + gap(tMrd);
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      cyc = 0; trigCyc = -1; doneCyc = -1;
      foreach (evCyc[i]) evCyc[i] = -1;
    end else begin
      cyc++;
      if (trigCyc < 0 && cfgLoad && cfgInitBit) begin
        trigCyc = cyc;
        buildSchedule();
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      int expCmd, expBa, expAddr;
      expCmd = 4'b0111; expBa = 0; expAddr = 0;
      for (int i = 1; i < 8; i++) begin
        if (evCyc[i] == cyc) begin
          case (i)
            1, 4: begin expCmd = 4'b0010; expAddr = 32'h400; end
            2:    begin expCmd = 4'b0000; expBa = 1;
                        expAddr = (int'(driveReduced) << 1) | (int'(qfcEnable) << 2); end
            3:    begin expCmd = 4'b0000; expAddr = modeWord(1'b1); end
            7:    begin expCmd = 4'b0000; expAddr = modeWord(1'b0); end
            default: expCmd = 4'b0001;
          endcase
        end
      end
      chk("R3 cke", ckeOut, (evCyc[0] >= 0 && cyc >= evCyc[0]) ? 1 : 0);
      chk("R4 R5 command pins", {csN, rasN, casN, weN}, expCmd);
      chk("R6 R7 bank", bankAddr, expBa);
      chk("R6 R7 address", memAddr, expAddr);
      chk("R8 done", initDone, (doneCyc >= 0 && cyc >= doneCyc) ? 1 : 0);
    end
  end

  // ---------- stimulus helpers ----------
  task automatic doReset();
    rstN = 1'b0; cfgLoad = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 cke", ckeOut, 0);
    chk("R1 pins", {csN, rasN, casN, weN}, 4'b0111);
    chk("R1 bank/addr", {bankAddr, memAddr}, 0);
    chk("R1 done", initDone, 0);
    rstN = 1'b1;
  endtask

  task automatic pulseLoad(input bit initBit);
    @(negedge clk);
    cfgInitBit = initBit; cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic waitEdge(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic waitDone();
    while (doneCyc < 0 || cyc < doneCyc + 2) @(negedge clk);
  endtask

  initial begin
    // scenario 1: early trigger, default timing, waits for settle count
    doReset();
    pulseLoad(1'b1);
    waitDone();
    chk("R8 done high after sequence", initDone, 1);
    pulseLoad(1'b1);          // R8: retrigger after done is ignored
    pulseLoad(1'b0);          // R8: clearing init bit has no effect
    repeat (20) @(negedge clk);
    chk("R8 done held", initDone, 1);

    // scenario 2: zero gaps act as one, burst 8 interleaved, CL 1.5, drive+QFC
    burstLenSel = 2'd2; burstInterleave = 1'b1; casSel = 2'd0;
    driveReduced = 1'b1; qfcEnable = 1'b1;
    tRp = 4'd0; tMrd = 4'd1; tRfc = 4'd0;
    doReset();
    pulseLoad(1'b0);          // R2: load with init bit clear
    waitEdge(STABLE + 20);
    chk("R2 no start without init bit", ckeOut, 0);
    pulseLoad(1'b1);
    waitDone();

    // scenario 3: late trigger, long gaps, burst 2, CL 2.5, retrigger mid-run
    burstLenSel = 2'd0; burstInterleave = 1'b0; casSel = 2'd2;
    driveReduced = 1'b0; qfcEnable = 1'b1;
    tRp = 4'd7; tMrd = 4'd15; tRfc = 4'd12;
    doReset();
    waitEdge(STABLE + 50);
    pulseLoad(1'b1);
    repeat (10) @(negedge clk);
    pulseLoad(1'b1);          // R9: trigger while running
    while (doneCyc < 0 || cyc < doneCyc - 1) @(negedge clk);
    chk("R9 done not yet", initDone, 0);
    @(negedge clk);
    chk("R9 done on schedule", initDone, 1);
    waitDone();

    // scenario 4: trigger exactly at settle limit, CL 3.0, burst 4
    burstLenSel = 2'd1; casSel = 2'd3; qfcEnable = 1'b0;
    tRp = 4'd2; tMrd = 4'd2; tRfc = 4'd2;
    doReset();
    waitEdge(STABLE - 2);
    pulseLoad(1'b1);
    waitDone();

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule